// File: doc/BRIEF.md
# Display Host Register Interface

This block is the processor-facing register port of a small dot-matrix text display controller. A host drives active-low chip-enable, write and read strobes, a register-space select line, five address lines and an 8-bit data bus. The block decodes each cycle to one of four storage targets. These are a per-digit character store, a pointer that names one of the user-defined glyph slots, the row store for those glyphs, and a control word. It returns read data on a registered output bus, and it also runs the clear command that blanks the character store.

User glyphs are written indirectly. One write loads the slot pointer. Each later row write then lands in the glyph that the pointer names, so a full glyph costs one pointer write and seven row writes. The control word drives the flash, blink and self-test enables used by the scanning logic. Its clear bit wipes only the characters and never the control word itself.

Top module: `disp_host_if`

## Requirements
- R1: With `reg_sel`=1 and addr[4:3]=2'b11, a write stores all 8 data bits in the character entry whose digit index is addr[2:0] (addr[2] most significant), and a read of that entry returns the same 8 bits.
- R2: With `reg_sel`=1 and addr[4:3]=2'b00, a write stores data bits 3..0 into the glyph pointer and ignores data bits 7..4 and addr[2:0]; a read returns the pointer in bits 3..0 and zeros in bits 7..4.
- R3: With `reg_sel`=1 and addr[4:3]=2'b01, a write stores data bits 4..0 as row addr[2:0] of the glyph the pointer names; a read returns that row in bits 4..0 and zeros in bits 7..5, and rows of other glyphs are untouched.
- R4: In glyph-row space, row index 7 is ignored on writes and reads back as 0.
- R5: A write takes place only on a clock edge that samples `cs_n`=0, `we_n`=0, `re_n`=1, `reg_sel`=1 and `rst_n`=1. A read takes place only with `cs_n`=0, `we_n`=1, `re_n`=0, `reg_sel`=1 and `rst_n`=1. Any other strobe combination, including both strobes low, changes no state and starts no read.
- R6: The clock edge that samples a read loads `rdata` and raises `rdata_oe` for the following cycle only. While `rdata_oe` is 0, `rdata` is 0.
- R7: With `reg_sel`=1 and addr[4:3]=2'b10, a write loads the control word: bit 0 drives `flash_en`, bit 1 drives `blink_en` and bit 2 drives `selftest_go`. A read returns those three bits in place, with bits 6..3 reading as 0.
- R8: A control write with bit 7 set makes all character entries 8'h20 on the next clock edge, and that edge overrides any character write sampled on it. Bit 7 reads back as 1 only before that edge and as 0 afterwards. The clear changes neither the control bits nor the glyph rows.
- R9: While `rst_n`=0, every character entry becomes 8'h20, and the control word, the glyph pointer, every glyph row and `rdata_oe` become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write strobe |
| re_n | input | 1 | Active-low read strobe |
| reg_sel | input | 1 | 1 selects the register space of this block |
| addr | input | 5 | Target in bits 4..3, digit or row index in bits 2..0 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, 0 when not valid |
| rdata_oe | output | 1 | High for the cycle in which `rdata` is valid |
| flash_en | output | 1 | Control word bit 0 |
| blink_en | output | 1 | Control word bit 1 |
| selftest_go | output | 1 | Control word bit 2 |

## Verification
All stores update on the same edge that samples the write. A read therefore returns the new value when it is sampled on the edge right after the write. Read data and `rdata_oe` appear one edge after the edge that samples the read strobe, so the bench compares them at the falling edge that follows. A clear becomes visible in the character store one edge after the control write, and the bench checks the pending clear bit in that gap. The behavioural model in the bench steps on every rising edge and is compared with the outputs at every falling edge, so an update that comes early or late shows as a mismatch in that exact cycle.

// File: rtl/dhi_pkg.sv
package dhi_pkg;

  // target select is addr[4:3]; the code values are the decode itself
  typedef enum logic [1:0] {
    TGT_PTR  = 2'b00,
    TGT_ROW  = 2'b01,
    TGT_CTRL = 2'b10,
    TGT_CHAR = 2'b11
  } tgt_e;

  localparam logic [7:0] BLANK_CODE = 8'h20;
  localparam int CTL_FLASH = 0;
  localparam int CTL_BLINK = 1;
  localparam int CTL_TEST  = 2;
  localparam int CTL_CLEAR = 7;

  function automatic tgt_e tgt_of(input logic [4:0] a);
    return tgt_e'(a[4:3]);
  endfunction

  function automatic logic is_write(input logic rst_n, input logic cs_n,
                                    input logic we_n, input logic re_n,
                                    input logic sel);
    return rst_n & sel & ~cs_n & ~we_n & re_n;
  endfunction

  function automatic logic is_read(input logic rst_n, input logic cs_n,
                                   input logic we_n, input logic re_n,
                                   input logic sel);
    return rst_n & sel & ~cs_n & we_n & ~re_n;
  endfunction

endpackage

// File: rtl/dhi_decode.sv
module dhi_decode
  import dhi_pkg::*;
(
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       reg_sel,
  input  logic [4:0] addr,
  output logic       wr_ev,
  output logic       rd_ev,
  output tgt_e       tgt
);
  assign wr_ev = is_write(rst_n, cs_n, we_n, re_n, reg_sel);
  assign rd_ev = is_read(rst_n, cs_n, we_n, re_n, reg_sel);
  assign tgt   = tgt_of(addr);
endmodule

// File: rtl/dhi_char_ram.sv
module dhi_char_ram #(
  parameter int          NUM_DIGITS = 8,
  parameter int          DW         = 8,
  parameter logic [7:0]  BLANK      = 8'h20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic                       clr,
  input  logic [$clog2(NUM_DIGITS)-1:0] idx,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rd_val,
  output logic [NUM_DIGITS*DW-1:0]   flat
);
  logic [DW-1:0] ent [NUM_DIGITS];

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_dig
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ent[d] <= DW'(BLANK);
      else if (clr)                          ent[d] <= DW'(BLANK);
      else if (we && idx == d[$clog2(NUM_DIGITS)-1:0]) ent[d] <= wdata;
    end
    assign flat[d*DW +: DW] = ent[d];
  end

  assign rd_val = ent[idx];
endmodule

// File: rtl/dhi_glyph_store.sv
module dhi_glyph_store #(
  parameter int GLYPHS = 16,
  parameter int ROWS   = 7,
  parameter int COLS   = 5,
  localparam int PW    = $clog2(GLYPHS),
  localparam int RW    = $clog2(ROWS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ptr_we,
  input  logic [PW-1:0]   ptr_wdata,
  input  logic            row_we,
  input  logic [RW-1:0]   row_idx,
  input  logic [COLS-1:0] row_wdata,
  output logic [PW-1:0]   ptr,
  output logic [COLS-1:0] row_rd
);
  localparam logic [RW-1:0] ROW_LIM = RW'(ROWS);

  logic [COLS-1:0] mem [GLYPHS][ROWS];
  logic            row_ok;

  assign row_ok = row_idx < ROW_LIM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_we) ptr <= ptr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < GLYPHS; g++)
        for (int r = 0; r < ROWS; r++)
          mem[g][r] <= '0;
    end else if (row_we && row_ok) begin
      mem[ptr][row_idx] <= row_wdata;
    end
  end

  assign row_rd = row_ok ? mem[ptr][row_idx] : '0;
endmodule

// File: rtl/dhi_ctrl.sv
module dhi_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       clr_req,
  input  logic [2:0] bits_in,
  output logic [2:0] bits,
  output logic       clr_fire
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits   <= '0;
      pend_q <= 1'b0;
    end else begin
      if (we) bits <= bits_in;
      pend_q <= we & clr_req;
    end
  end

  assign clr_fire = pend_q;
endmodule

// File: rtl/disp_host_if.sv
module disp_host_if
  import dhi_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int DW         = 8,
  parameter int GLYPHS     = 16,
  parameter int ROWS       = 7,
  parameter int COLS       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          re_n,
  input  logic          reg_sel,
  input  logic [4:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  output logic          flash_en,
  output logic          blink_en,
  output logic          selftest_go
);
  localparam int DIG_W = $clog2(NUM_DIGITS);
  localparam int PW    = $clog2(GLYPHS);
  localparam int RW    = $clog2(ROWS + 1);

  logic                     wr_ev, rd_ev;
  tgt_e                     tgt;
  logic                     clr_fire;
  logic [2:0]               ctrl_bits;
  logic [DW-1:0]            char_rd;
  logic [NUM_DIGITS*DW-1:0] char_flat;
  logic [PW-1:0]            ptr_q;
  logic [COLS-1:0]          row_rd;
  logic [DW-1:0]            rd_mux;

  dhi_decode u_dec (
    .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .re_n(re_n),
    .reg_sel(reg_sel), .addr(addr),
    .wr_ev(wr_ev), .rd_ev(rd_ev), .tgt(tgt)
  );

  dhi_char_ram #(.NUM_DIGITS(NUM_DIGITS), .DW(DW), .BLANK(BLANK_CODE)) u_chr (
    .clk(clk), .rst_n(rst_n),
    .we(wr_ev && tgt == TGT_CHAR), .clr(clr_fire),
    .idx(addr[DIG_W-1:0]), .wdata(wdata),
    .rd_val(char_rd), .flat(char_flat)
  );

  dhi_glyph_store #(.GLYPHS(GLYPHS), .ROWS(ROWS), .COLS(COLS)) u_gly (
    .clk(clk), .rst_n(rst_n),
    .ptr_we(wr_ev && tgt == TGT_PTR), .ptr_wdata(wdata[PW-1:0]),
    .row_we(wr_ev && tgt == TGT_ROW), .row_idx(addr[RW-1:0]),
    .row_wdata(wdata[COLS-1:0]),
    .ptr(ptr_q), .row_rd(row_rd)
  );

  dhi_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .we(wr_ev && tgt == TGT_CTRL), .clr_req(wdata[CTL_CLEAR]),
    .bits_in(wdata[CTL_TEST:CTL_FLASH]),
    .bits(ctrl_bits), .clr_fire(clr_fire)
  );

  always_comb begin
    rd_mux = '0;
    unique case (tgt)
      TGT_CHAR: rd_mux = char_rd;
      TGT_PTR:  rd_mux[PW-1:0] = ptr_q;
      TGT_ROW:  rd_mux[COLS-1:0] = row_rd;
      TGT_CTRL: begin
        rd_mux[CTL_TEST:CTL_FLASH] = ctrl_bits;
        rd_mux[CTL_CLEAR]          = clr_fire;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else begin
      rdata    <= rd_ev ? rd_mux : '0;
      rdata_oe <= rd_ev;
    end
  end

  assign flash_en    = ctrl_bits[CTL_FLASH];
  assign blink_en    = ctrl_bits[CTL_BLINK];
  assign selftest_go = ctrl_bits[CTL_TEST];
endmodule

// File: rtl/dhi_checks.sv
module dhi_checks
  import dhi_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int DW         = 8,
  parameter int ROWS       = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_ev,
  input logic                     rd_ev,
  input tgt_e                     tgt,
  input logic [4:0]               addr,
  input logic [DW-1:0]            wdata,
  input logic [DW-1:0]            rdata,
  input logic                     rdata_oe,
  input logic [3:0]               ptr_q,
  input logic                     clr_fire,
  input logic [NUM_DIGITS*DW-1:0] char_flat,
  input logic [2:0]               ctrl_bits
);
  // R6
  oe_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> $past(rd_ev));

  // R6
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> rdata == '0);

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ev && tgt == TGT_PTR) |-> ptr_q == $past(wdata[3:0]));

  // R8
  clear_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_fire) |-> char_flat == {NUM_DIGITS{DW'(BLANK_CODE)}});

  // R8
  clear_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire && !(wr_ev && tgt == TGT_CTRL)) |=> $stable(ctrl_bits));

  // R4
  row7_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && $past(tgt == TGT_ROW && addr[2:0] >= 3'(ROWS))) |-> rdata == '0);
endmodule

bind disp_host_if dhi_checks u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .rd_ev(rd_ev), .tgt(tgt),
  .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
  .ptr_q(ptr_q), .clr_fire(clr_fire), .char_flat(char_flat),
  .ctrl_bits(ctrl_bits)
);

// File: tb/disp_host_if_tb_top.sv
module disp_host_if_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, we_n = 1'b1, re_n = 1'b1, reg_sel = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rdata_oe, flash_en, blink_en, selftest_go;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  disp_host_if dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .re_n(re_n),
    .reg_sel(reg_sel), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe), .flash_en(flash_en), .blink_en(blink_en),
    .selftest_go(selftest_go)
  );

  // behavioural reference
  int m_chr [8];
  int m_gly [16][8];
  int m_ptr, m_ctl, m_clr, m_rd, m_oe;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_chr[i]) m_chr[i] = 32;
      foreach (m_gly[g, r]) m_gly[g][r] = 0;
      m_ptr = 0; m_ctl = 0; m_clr = 0; m_rd = 0; m_oe = 0;
    end else begin
      bit w, r; int a, sel, v, next_clr;
      w = reg_sel && !cs_n && !we_n && re_n;
      r = reg_sel && !cs_n && we_n && !re_n;
      a = addr; sel = a / 8; v = 0;
      if (r) begin
        if (sel == 3) v = m_chr[a % 8];
        else if (sel == 0) v = m_ptr;
        else if (sel == 1) v = m_gly[m_ptr][a % 8];
        else v = m_ctl + (m_clr ? 128 : 0);
      end
      m_rd = v; m_oe = r;
      next_clr = 0;
      if (w && sel == 3 && !m_clr) m_chr[a % 8] = wdata;
      if (w && sel == 0) m_ptr = wdata % 16;
      if (w && sel == 1 && (a % 8) != 7) m_gly[m_ptr][a % 8] = wdata % 32;
      if (w && sel == 2) begin m_ctl = wdata % 8; next_clr = wdata[7]; end
      if (m_clr) foreach (m_chr[i]) m_chr[i] = 32;
      m_clr = next_clr;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every falling edge: outputs against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 rdata per cycle", rdata, m_rd);
      chk("R6 rdata_oe per cycle", rdata_oe, m_oe);
      chk("R7 control outputs", {selftest_go, blink_en, flash_en}, m_ctl);
    end
  end

  task automatic idle();
    cs_n = 1; we_n = 1; re_n = 1; reg_sel = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    reg_sel = 1; cs_n = 0; we_n = 0; re_n = 1; addr = a; wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [4:0] a, input int exp, input string tag);
    reg_sel = 1; cs_n = 0; we_n = 1; re_n = 0; addr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
    chk({tag, " oe"}, rdata_oe, 1);
    idle();
  endtask

  localparam logic [1:0] S_PTR = 2'b00, S_ROW = 2'b01, S_CTL = 2'b10, S_CHR = 2'b11;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    chk("R9 oe after reset", rdata_oe, 0);
    chk("R9 rdata after reset", rdata, 0);
    rd({S_CHR, 3'd0}, 8'h20, "R9 char0 blank");
    rd({S_CHR, 3'd7}, 8'h20, "R9 char7 blank");
    rd({S_PTR, 3'd0}, 0, "R9 pointer zero");
    rd({S_ROW, 3'd0}, 0, "R9 glyph row zero");
    rd({S_CTL, 3'd0}, 0, "R9 control zero");

    // R1 character store
    for (int i = 0; i < 8; i++) wr({S_CHR, 3'(i)}, 8'h41 + 8'(i));
    wr({S_CHR, 3'd5}, 8'h85);
    rd({S_CHR, 3'd0}, 8'h41, "R1 digit0");
    rd({S_CHR, 3'd5}, 8'h85, "R1 digit5 full byte");
    rd({S_CHR, 3'd7}, 8'h48, "R1 digit7");

    // R2 pointer: upper data bits and low address bits ignored
    wr({S_PTR, 3'd5}, 8'hA7);
    rd({S_PTR, 3'd2}, 8'h07, "R2 pointer masked");

    // R3 glyph rows for slot 7
    for (int r = 0; r < 7; r++) wr({S_ROW, 3'(r)}, 8'hE0 | 8'((r * 3 + 1) % 32));
    rd({S_ROW, 3'd3}, 10, "R3 row3 slot7");
    wr({S_PTR, 3'd0}, 8'h02);
    wr({S_ROW, 3'd3}, 8'h15);
    rd({S_ROW, 3'd3}, 8'h15, "R3 row3 slot2");
    wr({S_PTR, 3'd0}, 8'h07);
    rd({S_ROW, 3'd3}, 10, "R3 slot7 untouched");

    // R4 row 7
    wr({S_ROW, 3'd7}, 8'h1F);
    rd({S_ROW, 3'd7}, 0, "R4 row7 reads zero");
    rd({S_ROW, 3'd6}, 19, "R4 row6 unchanged");

    // R5 strobe qualification
    cs_n = 1; we_n = 0; re_n = 1; reg_sel = 1; addr = {S_CHR, 3'd1}; wdata = 8'h00;
    @(negedge clk); idle();
    cs_n = 0; we_n = 0; re_n = 0; reg_sel = 1; addr = {S_CHR, 3'd1};
    @(negedge clk);
    chk("R5 both strobes no read", rdata_oe, 0);
    idle();
    cs_n = 0; we_n = 0; re_n = 1; reg_sel = 0; addr = {S_CHR, 3'd1};
    @(negedge clk); idle();
    cs_n = 0; we_n = 1; re_n = 0; reg_sel = 0;
    @(negedge clk);
    chk("R5 unselected read oe", rdata_oe, 0);
    chk("R5 unselected read data", rdata, 0);
    idle();
    rd({S_CHR, 3'd1}, 8'h42, "R5 digit1 unchanged");

    // R7 control word
    wr({S_CTL, 3'd0}, 8'h7B);
    rd({S_CTL, 3'd0}, 8'h03, "R7 control masked");
    chk("R7 flash_en", flash_en, 1);
    chk("R7 selftest_go off", selftest_go, 0);
    wr({S_CTL, 3'd0}, 8'h04);
    chk("R7 selftest_go on", selftest_go, 1);

    // R8 clear
    wr({S_CTL, 3'd0}, 8'h83);
    rd({S_CTL, 3'd0}, 8'h83, "R8 clear pending");
    rd({S_CTL, 3'd0}, 8'h03, "R8 clear bit self-clears");
    rd({S_CHR, 3'd0}, 8'h20, "R8 digit0 blank");
    rd({S_CHR, 3'd5}, 8'h20, "R8 digit5 blank");
    chk("R8 blink kept", blink_en, 1);
    rd({S_ROW, 3'd3}, 10, "R8 glyph rows kept");
    wr({S_CHR, 3'd2}, 8'h33);
    wr({S_CTL, 3'd0}, 8'h80);
    wr({S_CHR, 3'd2}, 8'h55);
    rd({S_CHR, 3'd2}, 8'h20, "R8 clear beats write");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule